// File: doc/BRIEF.md
# Coherence Message Event Classifier

This block sits in front of a line-level coherence controller in a mid-level private cache. It sees the heads of three inbound message queues:

- responses coming up from the lower level;
- requests forwarded down from the lower level;
- requests and acknowledgements coming from the cache above.

Each cycle it picks one head message. It pops that message and turns it into a single line event for the controller.

To classify a message, the block uses four things. It uses the message's type, the line's state as looked up by the controller, and whether the line is present. For upper-level requests it also uses whether a free way exists in the set. When an upper request misses and the set is full, the block does not issue an event for the request. It issues an event against the victim line named on a separate input. That event is either an eviction of the victim or a request to invalidate the victim's copy above first.

The pop strobe for the chosen queue is combinational, so the queue can dequeue in the same cycle. The event (source queue, target address and event code) is registered and appears one cycle later. Queue storage, tag lookup and victim choice are outside this block.

Top module: `coh_evt_classifier`

## Requirements

Line-state codes (5 bits):

| Code | State | Code | State | Code | State | Code | State |
|---|---|---|---|---|---|---|---|
| 0 | absent | 1 | idle | 2 | shared-above | 3 | shared |
| 4 | excl-above | 5 | excl | 6 | mod-above | 7 | mod |
| 8 | wait-shared | 9 | wait-excl | 10 | wait-upgrade | 11 | wait-shared-invalidated |
| 12 | wait-wbdone | 13 | sink-wbdone | 14 | upinv-shared | 15 | upinv-excl |
| 16 | upinv-mod | 17 | upinv-mod-rw | 18 | upinv-upgrade | | |

Event codes (5 bits):

| Code | Event | Code | Event | Code | Event |
|---|---|---|---|---|---|
| 0 | load | 1 | store | 2 | writeback |
| 3 | up-data-ack | 4 | up-ack | 5 | invalidate |
| 6 | upinv-self | 7 | upinv-other | 8 | replace |
| 9 | fwd-excl | 10 | fwd-shared | 11 | data |
| 12 | data-excl | 13 | data-peer | 14 | data-all |
| 15 | ack | 16 | ack-all | 17 | wb-done |

- R1: Queues have fixed priority, highest first: response (index 0), then forwarded (index 1), then upper (index 2). pop_o bit q marks queue q. At most one pop_o bit is high in a cycle. A valid, legal, non-stalled message is always taken ahead of any lower queue.
- R2: When pop_o is high in a cycle, evt_vld_o is high on the next cycle. At the same time evt_src_o carries the popped queue index and evt_addr_o and evt_code_o carry the event. In a cycle after no event was chosen, evt_vld_o, evt_src_o, evt_addr_o and evt_code_o are all zero.
- R3: Response types are 0 data, 1 exclusive data, 2 ack and 3 writeback ack. Exclusive data gives event 12 and writeback ack gives event 17, regardless of line state.
- R4: A data response (type 0) is classified in this order:
  - If the line state is 8 or 11 and rsp_peer_i is high, it gives event 13.
  - Otherwise, if rsp_pend_i equals rsp_ackcnt_i, it gives event 14.
  - Otherwise it gives event 11.
- R5: An ack response (type 2) gives event 16 when rsp_pend_i equals rsp_ackcnt_i, and event 15 otherwise.
- R6: Forwarded types are 0 invalidate, 1 exclusive read, 2 upgrade and 3 shared read. If the line state is 2, 4, 6, 14, 15, 16 or 18, any of these gives event 7. Otherwise type 0 gives 5, types 1 and 2 give 9, and type 3 gives 10.
- R7: Upper types are 0 shared read, 1 exclusive read, 2 upgrade and 3 writeback. When upr_hit_i or upr_free_i is high, these give, in that order, events 0, 1, 1 and 2, targeting upr_addr_i.
- R8: Upper type 4 (invalidate ack with data) gives event 3, and upper type 5 (invalidate ack) gives event 4. Neither depends on hit, free way or line state.
- R9: An upper type 0 to 3 with upr_hit_i and upr_free_i both low targets vic_addr_i. It gives event 6 if vic_state_i is 2, 4, 6, 14, 15, 16 or 18, and event 8 otherwise.
- R10: An upper load or store is a stall when the line state is one of 8 to 17. A victim replace (event 8) is also a stall when vic_state_i is one of 8 to 17. A stalled message is not popped and produces no event. Writeback and upinv-self events never stall.
- R11: A head message with an unrecognised type (response or forwarded type above 3, upper type above 5) raises err_o on the next cycle. It pops nothing and produces no event, and no lower-priority queue is served in that cycle.
- R12: While rst_n is low, pop_o is zero. On the cycle after a reset edge, evt_vld_o, evt_src_o, evt_addr_o, evt_code_o and err_o are all zero.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rsp_vld_i | input | 1 | Response queue head valid |
| rsp_type_i | input | 3 | Response type |
| rsp_addr_i | input | ADDR_W | Response line address |
| rsp_state_i | input | 5 | Line state for the response address |
| rsp_peer_i | input | 1 | Response data came from a peer cache |
| rsp_pend_i | input | CNT_W | Acks still pending for the line |
| rsp_ackcnt_i | input | CNT_W | Ack count carried by the response |
| fwd_vld_i | input | 1 | Forwarded queue head valid |
| fwd_type_i | input | 3 | Forwarded request type |
| fwd_addr_i | input | ADDR_W | Forwarded line address |
| fwd_state_i | input | 5 | Line state for the forwarded address |
| upr_vld_i | input | 1 | Upper queue head valid |
| upr_type_i | input | 3 | Upper message type |
| upr_addr_i | input | ADDR_W | Upper line address |
| upr_state_i | input | 5 | Line state for the upper address |
| upr_hit_i | input | 1 | Upper address has an entry in this cache |
| upr_free_i | input | 1 | The set has a free way |
| vic_addr_i | input | ADDR_W | Victim line address for a full set |
| vic_state_i | input | 5 | Victim line state |
| pop_o | output | 3 | One-hot dequeue strobe, bit per queue |
| evt_vld_o | output | 1 | Registered event valid |
| evt_src_o | output | 2 | Queue index of the event |
| evt_addr_o | output | ADDR_W | Event target address |
| evt_code_o | output | 5 | Event code |
| err_o | output | 1 | Unrecognised message type seen |

## Verification

The bench builds the block with ADDR_W = 12 and CNT_W = 3. The narrow ack counter makes the largest pending and ack values (7) easy to drive, so the equality test behind the all-acks events is checked at its top boundary. A case where the difference would wrap is also checked. The all-ones victim address shows that the full address width is substituted on a full-set miss. A table of mixed queue patterns covers the priority, stall-skip and error-blocking paths. Directed steps then check reset behaviour while messages are present.

// File: rtl/coh_evt_pkg.sv
// Shared codes for the coherence message event classifier.
// Assumes the controller supplies 5-bit line states in the encoding below.
package coh_evt_pkg;

    typedef enum logic [4:0] {
        ST_ABSENT        = 5'd0,
        ST_IDLE          = 5'd1,
        ST_SH_UP         = 5'd2,
        ST_SH            = 5'd3,
        ST_EX_UP         = 5'd4,
        ST_EX            = 5'd5,
        ST_MOD_UP        = 5'd6,
        ST_MOD           = 5'd7,
        ST_WAIT_SH       = 5'd8,
        ST_WAIT_EX       = 5'd9,
        ST_WAIT_UPG      = 5'd10,
        ST_WAIT_SH_INV   = 5'd11,
        ST_WAIT_WBDONE   = 5'd12,
        ST_SINK_WBDONE   = 5'd13,
        ST_UPINV_SH      = 5'd14,
        ST_UPINV_EX      = 5'd15,
        ST_UPINV_MOD     = 5'd16,
        ST_UPINV_MOD_RW  = 5'd17,
        ST_UPINV_UPG     = 5'd18
    } line_st_e;

    typedef enum logic [4:0] {
        EV_LOAD        = 5'd0,
        EV_STORE       = 5'd1,
        EV_WB          = 5'd2,
        EV_UP_DATA_ACK = 5'd3,
        EV_UP_ACK      = 5'd4,
        EV_INV         = 5'd5,
        EV_UPINV_SELF  = 5'd6,
        EV_UPINV_OTHER = 5'd7,
        EV_REPLACE     = 5'd8,
        EV_FWD_EXCL    = 5'd9,
        EV_FWD_SH      = 5'd10,
        EV_DATA        = 5'd11,
        EV_DATA_EXCL   = 5'd12,
        EV_DATA_PEER   = 5'd13,
        EV_DATA_ALL    = 5'd14,
        EV_ACK         = 5'd15,
        EV_ACK_ALL     = 5'd16,
        EV_WB_DONE     = 5'd17
    } evt_e;

    localparam int NQ    = 3;
    localparam int Q_RSP = 0;
    localparam int Q_FWD = 1;
    localparam int Q_UPR = 2;

    localparam logic [2:0] RT_DATA  = 3'd0;
    localparam logic [2:0] RT_DEXCL = 3'd1;
    localparam logic [2:0] RT_ACK   = 3'd2;
    localparam logic [2:0] RT_WBACK = 3'd3;

    localparam logic [2:0] FT_INV   = 3'd0;
    localparam logic [2:0] FT_GETX  = 3'd1;
    localparam logic [2:0] FT_UPG   = 3'd2;
    localparam logic [2:0] FT_GETS  = 3'd3;

    localparam logic [2:0] UT_GETS  = 3'd0;
    localparam logic [2:0] UT_GETX  = 3'd1;
    localparam logic [2:0] UT_UPG   = 3'd2;
    localparam logic [2:0] UT_PUTX  = 3'd3;
    localparam logic [2:0] UT_IDATA = 3'd4;
    localparam logic [2:0] UT_IACK  = 3'd5;

    // True when a copy of the line is held in the cache above.
    function automatic logic held_above(input logic [4:0] st);
        case (st)
            ST_SH_UP, ST_EX_UP, ST_MOD_UP,
            ST_UPINV_SH, ST_UPINV_EX, ST_UPINV_MOD, ST_UPINV_UPG: held_above = 1'b1;
            default: held_above = 1'b0;
        endcase
    endfunction

    // True for states in which loads, stores and replacements must wait.
    function automatic logic busy_state(input logic [4:0] st);
        busy_state = (st >= ST_WAIT_SH) && (st <= ST_UPINV_MOD_RW);
    endfunction

endpackage

// File: rtl/cec_rsp_decode.sv
// Response-queue decoder: maps a lower-level response head to a line event.
// Assumes pending-ack and carried-ack counts share one width; never stalls.
module cec_rsp_decode
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              vld_i,
    input  logic [2:0]        type_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [4:0]        state_i,
    input  logic              peer_i,
    input  logic [CNT_W-1:0]  pend_i,
    input  logic [CNT_W-1:0]  ackcnt_i,
    output logic              c_vld_o,
    output logic              c_bad_o,
    output logic              c_stall_o,
    output evt_e              c_evt_o,
    output logic [ADDR_W-1:0] c_addr_o
);

    logic last_ack;
    logic wait_shared;

    assign last_ack    = (pend_i == ackcnt_i);
    assign wait_shared = (state_i == ST_WAIT_SH) || (state_i == ST_WAIT_SH_INV);

    // Classify by response type, line state and remaining ack count.
    always_comb begin
        c_bad_o = 1'b0;
        c_evt_o = EV_DATA;
        case (type_i)
            RT_DEXCL: c_evt_o = EV_DATA_EXCL;
            RT_WBACK: c_evt_o = EV_WB_DONE;
            RT_ACK:   c_evt_o = last_ack ? EV_ACK_ALL : EV_ACK;
            RT_DATA: begin
                if (wait_shared && peer_i) c_evt_o = EV_DATA_PEER;
                else if (last_ack)         c_evt_o = EV_DATA_ALL;
                else                       c_evt_o = EV_DATA;
            end
            default:  c_bad_o = 1'b1;
        endcase
    end

    assign c_vld_o   = vld_i;
    assign c_stall_o = 1'b0;
    assign c_addr_o  = addr_i;

endmodule

// File: rtl/cec_fwd_decode.sv
// Forwarded-request decoder: maps a lower-level request head to a line event.
// Lines held above are turned into an upper invalidation on behalf of others.
module cec_fwd_decode
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              vld_i,
    input  logic [2:0]        type_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [4:0]        state_i,
    output logic              c_vld_o,
    output logic              c_bad_o,
    output logic              c_stall_o,
    output evt_e              c_evt_o,
    output logic [ADDR_W-1:0] c_addr_o
);

    logic above;

    assign above = held_above(state_i);

    // Pick the forwarded event, or the upper invalidation when held above.
    always_comb begin
        c_bad_o = 1'b0;
        c_evt_o = EV_INV;
        case (type_i)
            FT_INV:          c_evt_o = above ? EV_UPINV_OTHER : EV_INV;
            FT_GETX, FT_UPG: c_evt_o = above ? EV_UPINV_OTHER : EV_FWD_EXCL;
            FT_GETS:         c_evt_o = above ? EV_UPINV_OTHER : EV_FWD_SH;
            default:         c_bad_o = 1'b1;
        endcase
    end

    assign c_vld_o   = vld_i;
    assign c_stall_o = 1'b0;
    assign c_addr_o  = addr_i;

endmodule

// File: rtl/cec_upr_decode.sv
// Upper-queue decoder: maps requests and acks from the cache above to events.
// On a miss with a full set it targets the supplied victim instead.
module cec_upr_decode
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              vld_i,
    input  logic [2:0]        type_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [4:0]        state_i,
    input  logic              hit_i,
    input  logic              free_i,
    input  logic [ADDR_W-1:0] vic_addr_i,
    input  logic [4:0]        vic_state_i,
    output logic              c_vld_o,
    output logic              c_bad_o,
    output logic              c_stall_o,
    output evt_e              c_evt_o,
    output logic [ADDR_W-1:0] c_addr_o
);

    logic room;
    evt_e req_evt;

    assign room = hit_i || free_i;

    // Map a request type to its own-line event.
    always_comb begin
        case (type_i)
            UT_GETS:         req_evt = EV_LOAD;
            UT_GETX, UT_UPG: req_evt = EV_STORE;
            default:         req_evt = EV_WB;
        endcase
    end

    // Select event, target and stall for the upper head message.
    always_comb begin
        c_bad_o   = 1'b0;
        c_stall_o = 1'b0;
        c_evt_o   = EV_LOAD;
        c_addr_o  = addr_i;
        case (type_i)
            UT_IDATA: c_evt_o = EV_UP_DATA_ACK;
            UT_IACK:  c_evt_o = EV_UP_ACK;
            UT_GETS, UT_GETX, UT_UPG, UT_PUTX: begin
                if (room) begin
                    c_evt_o   = req_evt;
                    c_stall_o = (req_evt != EV_WB) && busy_state(state_i);
                end else begin
                    c_addr_o  = vic_addr_i;
                    c_evt_o   = held_above(vic_state_i) ? EV_UPINV_SELF : EV_REPLACE;
                    c_stall_o = !held_above(vic_state_i) && busy_state(vic_state_i);
                end
            end
            default:  c_bad_o = 1'b1;
        endcase
    end

    assign c_vld_o = vld_i;

endmodule

// File: rtl/cec_pick.sv
// Fixed-priority pick over per-queue candidates, lowest index first.
// Stalled candidates are skipped; a bad type stops the search with an error.
module cec_pick
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NQ_P   = 3
) (
    input  logic              cand_vld_i   [NQ_P],
    input  logic              cand_bad_i   [NQ_P],
    input  logic              cand_stall_i [NQ_P],
    input  evt_e              cand_evt_i   [NQ_P],
    input  logic [ADDR_W-1:0] cand_addr_i  [NQ_P],
    output logic              sel_vld_o,
    output logic [IDX_W-1:0]  sel_idx_o,
    output evt_e              sel_evt_o,
    output logic [ADDR_W-1:0] sel_addr_o,
    output logic              err_o,
    output logic [NQ_P-1:0]   pop_o
);

    localparam int IDX_W = (NQ_P > 1) ? $clog2(NQ_P) : 1;

    // Walk queues in priority order and stop at the first decision.
    always_comb begin
        logic done;
        done       = 1'b0;
        sel_vld_o  = 1'b0;
        sel_idx_o  = '0;
        sel_evt_o  = EV_LOAD;
        sel_addr_o = '0;
        err_o      = 1'b0;
        pop_o      = '0;
        for (int q = 0; q < NQ_P; q++) begin
            if (!done && cand_vld_i[q]) begin
                if (cand_bad_i[q]) begin
                    err_o = 1'b1;
                    done  = 1'b1;
                end else if (!cand_stall_i[q]) begin
                    sel_vld_o  = 1'b1;
                    sel_idx_o  = IDX_W'(q);
                    sel_evt_o  = cand_evt_i[q];
                    sel_addr_o = cand_addr_i[q];
                    pop_o[q]   = 1'b1;
                    done       = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/coh_evt_classifier.sv
// Top of the coherence message event classifier. Decodes the three queue
// heads, picks one by priority, pops it at once and registers the event.
// Assumes line states are looked up by the controller for each head address.
module coh_evt_classifier
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_vld_i,
    input  logic [2:0]        rsp_type_i,
    input  logic [ADDR_W-1:0] rsp_addr_i,
    input  logic [4:0]        rsp_state_i,
    input  logic              rsp_peer_i,
    input  logic [CNT_W-1:0]  rsp_pend_i,
    input  logic [CNT_W-1:0]  rsp_ackcnt_i,
    input  logic              fwd_vld_i,
    input  logic [2:0]        fwd_type_i,
    input  logic [ADDR_W-1:0] fwd_addr_i,
    input  logic [4:0]        fwd_state_i,
    input  logic              upr_vld_i,
    input  logic [2:0]        upr_type_i,
    input  logic [ADDR_W-1:0] upr_addr_i,
    input  logic [4:0]        upr_state_i,
    input  logic              upr_hit_i,
    input  logic              upr_free_i,
    input  logic [ADDR_W-1:0] vic_addr_i,
    input  logic [4:0]        vic_state_i,
    output logic [2:0]        pop_o,
    output logic              evt_vld_o,
    output logic [1:0]        evt_src_o,
    output logic [ADDR_W-1:0] evt_addr_o,
    output logic [4:0]        evt_code_o,
    output logic              err_o
);

    localparam int IDX_W = $clog2(NQ);

    logic              c_vld   [NQ];
    logic              c_bad   [NQ];
    logic              c_stall [NQ];
    evt_e              c_evt   [NQ];
    logic [ADDR_W-1:0] c_addr  [NQ];

    logic              sel_vld;
    logic [IDX_W-1:0]  sel_idx;
    evt_e              sel_evt;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_err;
    logic [NQ-1:0]     sel_pop;

    cec_rsp_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) rsp_dec_i (
        .vld_i    (rsp_vld_i),
        .type_i   (rsp_type_i),
        .addr_i   (rsp_addr_i),
        .state_i  (rsp_state_i),
        .peer_i   (rsp_peer_i),
        .pend_i   (rsp_pend_i),
        .ackcnt_i (rsp_ackcnt_i),
        .c_vld_o  (c_vld[Q_RSP]),
        .c_bad_o  (c_bad[Q_RSP]),
        .c_stall_o(c_stall[Q_RSP]),
        .c_evt_o  (c_evt[Q_RSP]),
        .c_addr_o (c_addr[Q_RSP])
    );

    cec_fwd_decode #(.ADDR_W(ADDR_W)) fwd_dec_i (
        .vld_i    (fwd_vld_i),
        .type_i   (fwd_type_i),
        .addr_i   (fwd_addr_i),
        .state_i  (fwd_state_i),
        .c_vld_o  (c_vld[Q_FWD]),
        .c_bad_o  (c_bad[Q_FWD]),
        .c_stall_o(c_stall[Q_FWD]),
        .c_evt_o  (c_evt[Q_FWD]),
        .c_addr_o (c_addr[Q_FWD])
    );

    cec_upr_decode #(.ADDR_W(ADDR_W)) upr_dec_i (
        .vld_i      (upr_vld_i),
        .type_i     (upr_type_i),
        .addr_i     (upr_addr_i),
        .state_i    (upr_state_i),
        .hit_i      (upr_hit_i),
        .free_i     (upr_free_i),
        .vic_addr_i (vic_addr_i),
        .vic_state_i(vic_state_i),
        .c_vld_o    (c_vld[Q_UPR]),
        .c_bad_o    (c_bad[Q_UPR]),
        .c_stall_o  (c_stall[Q_UPR]),
        .c_evt_o    (c_evt[Q_UPR]),
        .c_addr_o   (c_addr[Q_UPR])
    );

    cec_pick #(.ADDR_W(ADDR_W), .NQ_P(NQ)) pick_i (
        .cand_vld_i  (c_vld),
        .cand_bad_i  (c_bad),
        .cand_stall_i(c_stall),
        .cand_evt_i  (c_evt),
        .cand_addr_i (c_addr),
        .sel_vld_o   (sel_vld),
        .sel_idx_o   (sel_idx),
        .sel_evt_o   (sel_evt),
        .sel_addr_o  (sel_addr),
        .err_o       (sel_err),
        .pop_o       (sel_pop)
    );

    // Dequeue strobe is held off while in reset.
    assign pop_o = rst_n ? sel_pop : '0;

    // Register the chosen event; idle fields read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_vld_o  <= 1'b0;
            evt_src_o  <= '0;
            evt_addr_o <= '0;
            evt_code_o <= '0;
            err_o      <= 1'b0;
        end else begin
            evt_vld_o  <= sel_vld;
            evt_src_o  <= sel_vld ? 2'(sel_idx) : 2'd0;
            evt_addr_o <= sel_vld ? sel_addr : '0;
            evt_code_o <= sel_vld ? 5'(sel_evt) : 5'd0;
            err_o      <= sel_err;
        end
    end

endmodule

// File: rtl/cec_chk.sv
// Checker for the coherence message event classifier; bound to the top.
// Relates queue inputs, pop strobes and registered event outputs over time.
module cec_chk
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_vld_i,
    input logic [2:0]        rsp_type_i,
    input logic              fwd_vld_i,
    input logic              upr_vld_i,
    input logic [2:0]        upr_type_i,
    input logic [4:0]        upr_state_i,
    input logic              upr_hit_i,
    input logic              upr_free_i,
    input logic [ADDR_W-1:0] vic_addr_i,
    input logic [2:0]        pop_o,
    input logic              evt_vld_o,
    input logic [1:0]        evt_src_o,
    input logic [ADDR_W-1:0] evt_addr_o,
    input logic              err_o
);

    // R1
    pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_o));

    // R1
    rsp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld_i && rsp_type_i <= RT_WBACK) |-> pop_o[Q_RSP]);

    // R1
    upr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o[Q_UPR] |-> (!rsp_vld_i && !fwd_vld_i && upr_vld_i));

    // R2
    pop_to_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pop_o) |=> evt_vld_o);

    // R2
    fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o[Q_FWD] |=> (evt_src_o == 2'd1));

    // R9
    vic_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o[Q_UPR] && !upr_hit_i && !upr_free_i && upr_type_i <= UT_PUTX)
        |=> (evt_addr_o == $past(vic_addr_i)));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upr_vld_i && !rsp_vld_i && !fwd_vld_i && upr_hit_i &&
         upr_type_i == UT_GETS && upr_state_i == ST_WAIT_EX) |-> (pop_o == 3'b000));

    // R11
    err_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !evt_vld_o);

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!evt_vld_o && !err_o));

endmodule

bind coh_evt_classifier cec_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_vld_i  (rsp_vld_i),
    .rsp_type_i (rsp_type_i),
    .fwd_vld_i  (fwd_vld_i),
    .upr_vld_i  (upr_vld_i),
    .upr_type_i (upr_type_i),
    .upr_state_i(upr_state_i),
    .upr_hit_i  (upr_hit_i),
    .upr_free_i (upr_free_i),
    .vic_addr_i (vic_addr_i),
    .pop_o      (pop_o),
    .evt_vld_o  (evt_vld_o),
    .evt_src_o  (evt_src_o),
    .evt_addr_o (evt_addr_o),
    .err_o      (err_o)
);

// File: tb/coh_evt_classifier_tb.sv
// Table-driven bench for the coherence message event classifier.
module coh_evt_classifier_tb_top;

    localparam int AW = 12;
    localparam int CW = 3;
    localparam logic [AW-1:0] RA = 12'h111;
    localparam logic [AW-1:0] FA = 12'h222;
    localparam logic [AW-1:0] UA = 12'h333;
    localparam logic [AW-1:0] VA = 12'hFFF;

    typedef struct packed {
        logic [3:0] rq;
        logic rv; logic [2:0] rt; logic [4:0] rs; logic rp; logic [2:0] rpend; logic [2:0] rack;
        logic fv; logic [2:0] ft; logic [4:0] fs;
        logic uv; logic [2:0] ut; logic [4:0] us; logic uh; logic uf; logic [4:0] vs;
        logic [2:0] epop; logic evld; logic [1:0] esrc; logic evic; logic [4:0] ecode; logic eerr;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        '{3, 1,1,0,0,0,0, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,12,0}, // R3 exclusive data
        '{3, 1,3,0,0,0,0, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,17,0}, // R3 writeback ack
        '{4, 1,0,8,1,2,0, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,13,0}, // R4 peer data in wait-shared
        '{4, 1,0,11,1,2,0, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,13,0}, // R4 peer data in wait-shared-inv
        '{4, 1,0,8,0,3,3, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,14,0}, // R4 directory data, all acks
        '{4, 1,0,9,1,2,1, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,11,0}, // R4 peer data outside wait-shared
        '{4, 1,0,9,0,7,7, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,14,0}, // R4 max counts equal
        '{4, 1,0,9,0,0,7, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,11,0}, // R4 difference wraps to 1
        '{5, 1,2,9,0,1,1, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,16,0}, // R5 last ack
        '{5, 1,2,9,0,2,1, 0,0,0, 0,0,0,0,0,0, 1,1,0,0,15,0}, // R5 more acks pending
        '{1, 1,2,9,0,0,0, 1,0,3, 1,0,3,1,0,0, 1,1,0,0,16,0}, // R1 response beats all
        '{1, 0,0,0,0,0,0, 1,0,3, 1,0,3,1,0,0, 2,1,1,0,5,0},  // R1 forwarded beats upper
        '{6, 0,0,0,0,0,0, 1,1,4, 0,0,0,0,0,0, 2,1,1,0,7,0},  // R6 excl read, held above
        '{6, 0,0,0,0,0,0, 1,3,18, 0,0,0,0,0,0, 2,1,1,0,7,0}, // R6 shared read, upinv-upgrade
        '{6, 0,0,0,0,0,0, 1,2,7, 0,0,0,0,0,0, 2,1,1,0,9,0},  // R6 upgrade, not above
        '{6, 0,0,0,0,0,0, 1,3,5, 0,0,0,0,0,0, 2,1,1,0,10,0}, // R6 shared read, not above
        '{6, 0,0,0,0,0,0, 1,0,8, 0,0,0,0,0,0, 2,1,1,0,5,0},  // R6 invalidate in wait-shared
        '{7, 0,0,0,0,0,0, 0,0,0, 1,0,3,1,0,0, 4,1,2,0,0,0},  // R7 load hit
        '{7, 0,0,0,0,0,0, 0,0,0, 1,2,2,1,0,0, 4,1,2,0,1,0},  // R7 upgrade to store
        '{7, 0,0,0,0,0,0, 0,0,0, 1,3,6,1,0,0, 4,1,2,0,2,0},  // R7 writeback
        '{7, 0,0,0,0,0,0, 0,0,0, 1,1,0,0,1,0, 4,1,2,0,1,0},  // R7 miss with free way
        '{8, 0,0,0,0,0,0, 0,0,0, 1,4,0,0,0,0, 4,1,2,0,3,0},  // R8 inv ack with data
        '{8, 0,0,0,0,0,0, 0,0,0, 1,5,8,0,0,0, 4,1,2,0,4,0},  // R8 inv ack, busy line
        '{9, 0,0,0,0,0,0, 0,0,0, 1,0,0,0,0,4, 4,1,2,1,6,0},  // R9 victim held above
        '{9, 0,0,0,0,0,0, 0,0,0, 1,1,0,0,0,7, 4,1,2,1,8,0},  // R9 victim replace
        '{10, 0,0,0,0,0,0, 0,0,0, 1,0,9,1,0,0, 0,0,0,0,0,0}, // R10 load stalls
        '{10, 0,0,0,0,0,0, 0,0,0, 1,3,12,1,0,0, 4,1,2,0,2,0}, // R10 writeback never stalls
        '{10, 0,0,0,0,0,0, 0,0,0, 1,0,0,0,0,13, 0,0,0,0,0,0}, // R10 replace of busy victim
        '{10, 0,0,0,0,0,0, 0,0,0, 1,0,0,0,0,14, 4,1,2,1,6,0}, // R10 upinv-self not stalled
        '{11, 1,5,0,0,0,0, 1,0,3, 0,0,0,0,0,0, 0,0,0,0,0,1}, // R11 bad response blocks fwd
        '{11, 0,0,0,0,0,0, 1,6,3, 1,0,3,1,0,0, 0,0,0,0,0,1}, // R11 bad forwarded blocks upper
        '{11, 0,0,0,0,0,0, 0,0,0, 1,7,3,1,0,0, 0,0,0,0,0,1}, // R11 bad upper type
        '{2, 0,0,0,0,0,0, 0,0,0, 0,0,0,0,0,0, 0,0,0,0,0,0}   // R2 idle clears outputs
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rsp_vld, rsp_peer, fwd_vld, upr_vld, upr_hit, upr_free;
    logic [2:0] rsp_type, fwd_type, upr_type;
    logic [AW-1:0] rsp_addr, fwd_addr, upr_addr, vic_addr;
    logic [4:0] rsp_state, fwd_state, upr_state, vic_state;
    logic [CW-1:0] rsp_pend, rsp_ackcnt;
    logic [2:0] pop;
    logic evt_vld, err;
    logic [1:0] evt_src;
    logic [AW-1:0] evt_addr;
    logic [4:0] evt_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    coh_evt_classifier #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rsp_vld_i(rsp_vld), .rsp_type_i(rsp_type), .rsp_addr_i(rsp_addr),
        .rsp_state_i(rsp_state), .rsp_peer_i(rsp_peer), .rsp_pend_i(rsp_pend),
        .rsp_ackcnt_i(rsp_ackcnt),
        .fwd_vld_i(fwd_vld), .fwd_type_i(fwd_type), .fwd_addr_i(fwd_addr),
        .fwd_state_i(fwd_state),
        .upr_vld_i(upr_vld), .upr_type_i(upr_type), .upr_addr_i(upr_addr),
        .upr_state_i(upr_state), .upr_hit_i(upr_hit), .upr_free_i(upr_free),
        .vic_addr_i(vic_addr), .vic_state_i(vic_state),
        .pop_o(pop), .evt_vld_o(evt_vld), .evt_src_o(evt_src),
        .evt_addr_o(evt_addr), .evt_code_o(evt_code), .err_o(err)
    );

    task automatic apply(input vec_t v);
        rsp_vld = v.rv; rsp_type = v.rt; rsp_addr = RA; rsp_state = v.rs;
        rsp_peer = v.rp; rsp_pend = v.rpend; rsp_ackcnt = v.rack;
        fwd_vld = v.fv; fwd_type = v.ft; fwd_addr = FA; fwd_state = v.fs;
        upr_vld = v.uv; upr_type = v.ut; upr_addr = UA; upr_state = v.us;
        upr_hit = v.uh; upr_free = v.uf; vic_addr = VA; vic_state = v.vs;
    endtask

    task automatic check(input bit ok, input string what, input int rq,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input vec_t v);
        if (!v.evld) return '0;
        if (v.evic) return VA;
        case (v.esrc)
            2'd0:    return RA;
            2'd1:    return FA;
            default: return UA;
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        apply(TBL[0]);
        // R12: reset with a message present
        repeat (3) @(posedge clk);
        #2;
        check(pop == 3'b000, "pop in reset", 12, 32'(pop), 0);
        check(!evt_vld && !err && evt_code == 0 && evt_addr == 0 && evt_src == 0,
              "outputs in reset", 12, {evt_vld, err, evt_code}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(TBL[i]);
            #5;
            check(pop == TBL[i].epop, $sformatf("vec %0d pop", i), int'(TBL[i].rq),
                  32'(pop), 32'(TBL[i].epop));
            @(posedge clk);
            #1;
            check(evt_vld == TBL[i].evld && evt_src == TBL[i].esrc &&
                  evt_code == TBL[i].ecode && evt_addr == exp_addr(TBL[i]) &&
                  err == TBL[i].eerr,
                  $sformatf("vec %0d event {vld,src,code,err,addr}", i), int'(TBL[i].rq),
                  {evt_vld, evt_src, evt_code, err, evt_addr},
                  {TBL[i].evld, TBL[i].esrc, TBL[i].ecode, TBL[i].eerr, exp_addr(TBL[i])});
        end

        // R12: reset reasserted mid-stream clears a pending event
        @(negedge clk);
        apply(TBL[0]);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #5;
        check(pop == 3'b000, "pop during reassert", 12, 32'(pop), 0);
        @(posedge clk);
        #1;
        check(!evt_vld && evt_code == 0, "event after reassert", 12,
              {evt_vld, evt_code}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first event after release comes from the response queue
        @(posedge clk);
        #1;
        check(evt_vld && evt_src == 2'd0 && evt_code == 5'd12 && evt_addr == RA,
              "first event after release", 1, {evt_vld, evt_src, evt_code}, {1'b1, 2'd0, 5'd12});
        finish_run();
    end

    initial begin
        #(20 * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog expired: actual running expected done");
        finish_run();
    end

endmodule